// File: doc/BRIEF.md
# Memory Bank Protect and Rename Unit

This unit sits on the memory address path of a machine with four memory banks. Every access carries a logical bank number. A writable table maps that number to a physical bank, and there is no route around the table. Software can rewrite one table entry at a time, or return the whole table to the identity mapping.

The unit also has a restricted mode for guarding a supervisor. On entry, a four-bit mask taken from the I/O register marks some physical banks as protected. While the unit is restricted, these accesses each raise a one-cycle trap request toward interrupt channel 16 (octal):

- any access whose opcode class is illegal, an I/O transfer or a halt;
- an ordinary access that lands on a protected bank.

The first such fault is captured in a trap buffer. The buffer holds the logical bank and a cause code, and it keeps that record until software clears it.

Commands use `cmd_op` and are qualified by `cmd_valid`. The codes are: 0 enter restrict, 1 leave restrict, 2 rename, 3 reset names, 4 clear trap buffer.

Top module: `bpr_unit`

## Requirements
- R1: `phys_bank` equals the table entry for `acc_bank` in the same cycle. After reset the table is the identity, so logical n selects physical n.
- R2: A rename command makes logical name `io_val[3:2]` select physical bank `io_val[1:0]` from the next cycle on. The other three entries are unchanged.
- R3: A reset-names command restores the identity mapping for all four entries from the next cycle on.
- R4: An enter-restrict command sets restricted mode and loads the protect mask from `io_val[3:0]`. Bit n protects physical bank n, which is checked after translation.
- R5: A leave-restrict command clears every protect bit and leaves restricted mode. Later accesses of any class raise no trap.
- R6: In restricted mode, a valid access raises `trap_req` for exactly the next cycle when either condition holds: its class is 1 (illegal opcode), 2 (I/O transfer) or 3 (halt); or its class is 0 (normal) and it targets a protected physical bank.
- R7: The cause code is 0 for a protected bank, and otherwise equals the access class (1 illegal, 2 I/O transfer, 3 halt). The class code takes precedence when both conditions hold.
- R8: Reset leaves `trap_req` and `trap_valid` low. A trap that arrives while the buffer is empty loads the logical bank and cause and sets `trap_valid`. Later traps leave the buffer contents unchanged.
- R9: A clear-trap command empties the buffer. A trap in the same cycle as a clear is loaded into the emptied buffer.
- R10: Outside restricted mode, no access raises a trap, whatever its class or bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 enter, 1 leave, 2 rename, 3 reset names, 4 clear trap) |
| io_val | input | 18 | I/O register value; bits [3:0] carry the mask or rename fields |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_class | input | 2 | Opcode class: 0 normal, 1 illegal, 2 I/O transfer, 3 halt |
| acc_bank | input | 2 | Logical bank of the access |
| phys_bank | output | 2 | Translated physical bank select |
| trap_req | output | 1 | One-cycle trap request to interrupt channel 16 octal |
| trap_valid | output | 1 | Trap buffer holds a record |
| trap_bank | output | 2 | Logical bank of the recorded fault |
| trap_cause | output | 2 | Cause of the recorded fault |

## Verification
`phys_bank` is combinational. The bench reads it a moment after it drives `acc_bank`, in the same cycle. `trap_req`, `trap_valid`, `trap_bank` and `trap_cause` are each one register away from the access, so they are sampled at the falling edge after the next rising edge. A command acts on accesses presented from the cycle after its strobe; the bench therefore issues every access at least one cycle after the command and compares it against a reference table and mask that are updated at the same point.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
    typedef enum logic [2:0] {
        CMD_ENTER   = 3'd0,
        CMD_LEAVE   = 3'd1,
        CMD_RENAME  = 3'd2,
        CMD_RESET   = 3'd3,
        CMD_CLRTRAP = 3'd4
    } bpr_cmd_e;

    // Access classes; non-zero values double as trap cause codes
    localparam logic [1:0] CLS_NORMAL  = 2'd0;
    localparam logic [1:0] CLS_ILLEGAL = 2'd1;
    localparam logic [1:0] CLS_IOT     = 2'd2;
    localparam logic [1:0] CLS_HALT    = 2'd3;
    localparam logic [1:0] CAUSE_PROT  = 2'd0;
endpackage

// File: rtl/bpr_map.sv
module bpr_map #(
    parameter int NB = 4,
    parameter int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_rename,
    input  logic          do_reset,
    input  logic [BW-1:0] ren_src,
    input  logic [BW-1:0] ren_name,
    input  logic [BW-1:0] lookup,
    output logic [BW-1:0] phys
);
    typedef struct packed {
        logic [NB-1:0][BW-1:0] tbl;
    } map_st_t;

    map_st_t st_d, st_q;

    function automatic map_st_t ident();
        map_st_t r;
        for (int i = 0; i < NB; i++) r.tbl[i] = i[BW-1:0];
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (do_reset) begin
            st_d = ident();
        end else if (do_rename) begin
            st_d.tbl[ren_name] = ren_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ident();
        else        st_q <= st_d;
    end

    assign phys = st_q.tbl[lookup];

    // R2: rename writes the named entry with the source bank
    p_rename_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rename && !do_reset) |=> st_q.tbl[$past(ren_name)] == $past(ren_src));

    for (genvar g = 0; g < NB; g++) begin : g_ident_chk
        // R3: each entry returns to its own index after a reset-names command
        p_reset_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
            do_reset |=> st_q.tbl[g] == g[BW-1:0]);
    end
endmodule

// File: rtl/bpr_guard.sv
module bpr_guard
    import bpr_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_enter,
    input  logic          do_leave,
    input  logic [NB-1:0] mask_in,
    input  logic          acc_valid,
    input  logic [1:0]    acc_cls,
    input  logic [BW-1:0] phys,
    output logic          viol,
    output logic [1:0]    cause,
    output logic          trap_req
);
    typedef struct packed {
        logic          restr;
        logic [NB-1:0] mask;
        logic          req;
    } grd_st_t;

    grd_st_t st_d, st_q;
    logic    cls_bad, prot_hit;

    always_comb begin
        cls_bad  = acc_valid && st_q.restr && (acc_cls != CLS_NORMAL);
        prot_hit = acc_valid && st_q.restr && (acc_cls == CLS_NORMAL) && st_q.mask[phys];
        viol     = cls_bad || prot_hit;
        cause    = cls_bad ? acc_cls : CAUSE_PROT;

        st_d     = st_q;
        st_d.req = viol;
        if (do_enter) begin
            st_d.restr = 1'b1;
            st_d.mask  = mask_in;
        end else if (do_leave) begin
            st_d.restr = 1'b0;
            st_d.mask  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_req = st_q.req;

    p_enter_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_enter |=> (st_q.restr && st_q.mask == $past(mask_in)));
    p_leave_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_leave && !do_enter) |=> (!st_q.restr && st_q.mask == '0));
    p_class_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && st_q.restr && acc_cls != CLS_NORMAL) |=> trap_req);
    p_quiet_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.restr) |=> !trap_req);
endmodule

// File: rtl/bpr_trapbuf.sv
module bpr_trapbuf #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          viol,
    input  logic [1:0]    cause,
    input  logic [BW-1:0] bank,
    input  logic          clr,
    output logic          valid,
    output logic [BW-1:0] tbank,
    output logic [1:0]    tcause
);
    typedef struct packed {
        logic          valid;
        logic [BW-1:0] bank;
        logic [1:0]    cause;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.valid = 1'b0;
        if (viol && (!st_q.valid || clr)) begin
            st_d.valid = 1'b1;
            st_d.bank  = bank;
            st_d.cause = cause;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid  = st_q.valid;
    assign tbank  = st_q.bank;
    assign tcause = st_q.cause;

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !clr) |=> (st_q.valid && $stable(st_q.bank) && $stable(st_q.cause)));
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !viol) |=> !st_q.valid);
endmodule

// File: rtl/bpr_unit.sv
module bpr_unit
    import bpr_pkg::*;
#(
    parameter int NB   = 4,
    parameter int IO_W = 18,
    localparam int BW  = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [IO_W-1:0] io_val,
    input  logic            acc_valid,
    input  logic [1:0]      acc_class,
    input  logic [BW-1:0]   acc_bank,
    output logic [BW-1:0]   phys_bank,
    output logic            trap_req,
    output logic            trap_valid,
    output logic [BW-1:0]   trap_bank,
    output logic [1:0]      trap_cause
);
    logic       do_enter, do_leave, do_rename, do_reset, do_clr;
    logic       viol;
    logic [1:0] cause;

    always_comb begin
        do_enter  = cmd_valid && (cmd_op == CMD_ENTER);
        do_leave  = cmd_valid && (cmd_op == CMD_LEAVE);
        do_rename = cmd_valid && (cmd_op == CMD_RENAME);
        do_reset  = cmd_valid && (cmd_op == CMD_RESET);
        do_clr    = cmd_valid && (cmd_op == CMD_CLRTRAP);
    end

    bpr_map #(.NB(NB), .BW(BW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_rename (do_rename),
        .do_reset  (do_reset),
        .ren_src   (io_val[BW-1:0]),
        .ren_name  (io_val[2*BW-1:BW]),
        .lookup    (acc_bank),
        .phys      (phys_bank)
    );

    bpr_guard #(.NB(NB), .BW(BW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_enter  (do_enter),
        .do_leave  (do_leave),
        .mask_in   (io_val[NB-1:0]),
        .acc_valid (acc_valid),
        .acc_cls   (acc_class),
        .phys      (phys_bank),
        .viol      (viol),
        .cause     (cause),
        .trap_req  (trap_req)
    );

    bpr_trapbuf #(.BW(BW)) u_tbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .viol   (viol),
        .cause  (cause),
        .bank   (acc_bank),
        .clr    (do_clr),
        .valid  (trap_valid),
        .tbank  (trap_bank),
        .tcause (trap_cause)
    );

    // R8: a trap request always leaves a record in the buffer
    p_req_recorded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_valid);
endmodule

// File: tb/tb_bpr_unit.sv
module tb_bpr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [17:0] io_val = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_class = '0;
    logic [1:0]  acc_bank = '0;
    logic [1:0]  phys_bank;
    logic        trap_req, trap_valid;
    logic [1:0]  trap_bank, trap_cause;

    int n_cmp = 0, n_bad = 0;
    int ref_tbl[4];
    int ref_mask = 0;
    bit ref_restr = 0;
    bit ref_bufv = 0;
    int ref_bank = 0, ref_cause = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bpr_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .io_val(io_val), .acc_valid(acc_valid), .acc_class(acc_class),
        .acc_bank(acc_bank), .phys_bank(phys_bank), .trap_req(trap_req),
        .trap_valid(trap_valid), .trap_bank(trap_bank), .trap_cause(trap_cause)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ref_ident();
        for (int i = 0; i < 4; i++) ref_tbl[i] = i;
    endtask

    task automatic ref_cmd(int op, int io);
        case (op)
            0: begin ref_restr = 1; ref_mask = io & 15; end
            1: begin ref_restr = 0; ref_mask = 0; end
            2: ref_tbl[(io >> 2) & 3] = io & 3;
            3: ref_ident();
            4: ref_bufv = 0;
            default: ;
        endcase
    endtask

    task automatic send_cmd(int op, int io);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[2:0]; io_val = io[17:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        ref_cmd(op, io);
    endtask

    function automatic bit exp_viol(int cls, int bank);
        if (!ref_restr) return 0;
        if (cls != 0) return 1;
        return ((ref_mask >> ref_tbl[bank]) & 1) != 0;
    endfunction

    task automatic check_buf(string tag);
        chk({tag, " trap_valid"}, trap_valid, ref_bufv);
        if (ref_bufv) begin
            chk({tag, " trap_bank"}, trap_bank, ref_bank);
            chk({tag, " trap_cause"}, trap_cause, ref_cause);
        end
    endtask

    // Access at a falling edge; phys checked same cycle, trap one register later
    task automatic access(int cls, int bank, string tag);
        bit v;
        @(negedge clk);
        acc_valid = 1'b1; acc_class = cls[1:0]; acc_bank = bank[1:0];
        #1;
        chk({tag, " R1 phys_bank"}, phys_bank, ref_tbl[bank]);
        v = exp_viol(cls, bank);
        @(negedge clk);
        acc_valid = 1'b0;
        chk({tag, " R6 trap_req"}, trap_req, v);
        if (v && !ref_bufv) begin
            ref_bufv = 1; ref_bank = bank; ref_cause = (cls != 0) ? cls : 0;
        end
        check_buf(tag);
    endtask

    initial begin
        #(150000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        ref_ident();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset trap_req", trap_req, 0);
        chk("R8 reset trap_valid", trap_valid, 0);
        // R1 identity after reset, R10 no traps while open
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) access(c, b, "R10 open");

        // R2 / R3 rename sweep from identity
        for (int s = 0; s < 4; s++)
            for (int n = 0; n < 4; n++) begin
                send_cmd(3, 0);
                for (int b = 0; b < 4; b++) access(0, b, "R3 ident");
                send_cmd(2, s | (n << 2));
                for (int b = 0; b < 4; b++) access(0, b, "R2 rename");
            end
        // R2 swap via two renames
        send_cmd(3, 0);
        send_cmd(2, 1 | (0 << 2));
        send_cmd(2, 0 | (1 << 2));
        for (int b = 0; b < 4; b++) access(0, b, "R2 swap");

        // R4 / R6 mask sweep on protected physical banks
        send_cmd(3, 0);
        for (int m = 0; m < 16; m++) begin
            send_cmd(0, m | 18'h3fff0);
            for (int b = 0; b < 4; b++) begin
                access(0, b, "R4 mask");
                send_cmd(4, 0);
                check_buf("R9 clear");
            end
        end

        // R7 class causes with empty mask
        send_cmd(0, 0);
        for (int c = 1; c < 4; c++)
            for (int b = 0; b < 4; b++) begin
                access(c, b, "R7 class");
                send_cmd(4, 0);
            end
        // R7 class beats protection
        send_cmd(0, 15);
        access(2, 1, "R7 precedence");
        send_cmd(4, 0);

        // R8 frozen buffer
        send_cmd(0, 4);
        access(0, 2, "R8 first");
        access(3, 0, "R8 second");
        access(1, 1, "R8 third");

        // R9 clear and trap in the same cycle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4;
        acc_valid = 1'b1; acc_class = 2'd2; acc_bank = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0; acc_valid = 1'b0;
        ref_bufv = 1; ref_bank = 3; ref_cause = 2;
        chk("R9 same-cycle trap_req", trap_req, 1);
        check_buf("R9 same-cycle");
        send_cmd(4, 0);

        // R4 protection follows translation
        send_cmd(0, 8);
        send_cmd(2, 3 | (0 << 2));
        access(0, 0, "R4 renamed");
        send_cmd(4, 0);
        access(0, 1, "R4 unprotected");

        // R5 leave restrict: nothing traps
        send_cmd(1, 0);
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) access(c, b, "R5 leave");
        chk("R5 trap_valid", trap_valid, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule